// File: doc/BRIEF.md
# Biquad Coefficient Loader

This block takes biquad filter coefficients from a control processor and delivers them to a filter datapath that runs on its own clock. The control side drives one 32-bit command word and a strobe in the system clock domain. Each transaction is two words. The address word names a filter stage and a slot. The data word carries either a coefficient value or a commit command.

Each stage has a pending (shadow) set of five coefficients and an active set. Writes only touch the pending set. A commit to a stage copies its whole pending set into the active set and flips a per-stage toggle flag. The flag passes into the data clock through two flops. When the data side sees the flag change, it copies that stage's five active values into its output registers in one step. The filter therefore never sees a mix of old and new coefficients for a stage.

Stages are loaded one slot at a time and then committed. Commits to different stages are independent.

Top module: `coef_loader`

## Requirements
- R1: After reset, every coefficient on `coef_out` reads zero and stays zero until the first commit.
- R2: A coefficient written to a stage and slot and then committed appears on `coef_out` within a few data clock cycles.
- R3: The address word carries the slot in bits [2:0] and the stage in bits [31:3]. The coefficient value is the low COEF_W bits of the data word. Stage s slot k appears at `coef_out[(s*5+k)*COEF_W +: COEF_W]`. Slots 0 to 4 hold b0, b1, b2, -a2 and -a1.
- R4: A slot write that is not followed by a commit leaves `coef_out` unchanged.
- R5: A commit moves all five coefficients of a stage together. `coef_out` changes only in the data cycle in which a synchronized commit is seen.
- R6: A data word is ignored in either of two cases: its bit 31 is clear, or, for slots 0 to 4, any bit between the value field and bit 31 is set.
- R7: Slots 5 and 6, and any stage index at or above STAGES, are ignored. They change neither the pending nor the active values.
- R8: A commit updates only the addressed stage. Other stages keep their active values, and their pending writes are not applied.
- R9: A commit (slot 7 with bit 31 set) ignores the lower bits of its data word.
- R10: Each rising edge of the strobe gives at most one write or commit. Further words presented while the strobe stays high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (control) clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| cmd_strobe | input | 1 | High for the length of one command transaction |
| cmd_word | input | 32 | Address word, then data word |
| data_clk | input | 1 | Filter datapath clock |
| data_rst | input | 1 | Synchronous active-high reset, data domain |
| coef_out | output | STAGES*5*COEF_W | Active coefficients, by stage and slot, data domain |

## Verification
A wrong pending value stays hidden until that stage's commit. It then shows on `coef_out`, about three data clocks after the commit word, in exactly that stage's slot. A decoder that lets an illegal slot, stage, flag or extra word through shows up at the next commit as a changed coefficient that the model did not expect. A broken toggle or synchronizer shows either as a stage that never updates, or as `coef_out` changing when no commit was made.

// File: rtl/coef_if_pkg.sv
package coef_if_pkg;

    localparam int          NUM_SLOTS  = 5;
    localparam logic [2:0]  CMD_COMMIT = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_HOLD
    } dec_state_e;

    typedef struct packed {
        logic [28:0] stage;
        logic [2:0]  slot;
    } addr_word_t;

    function automatic logic is_coef_slot(input logic [2:0] slot);
        return slot < 3'(NUM_SLOTS);
    endfunction

endpackage

// File: rtl/coef_decoder.sv
module coef_decoder
    import coef_if_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int COEF_W = 25,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [31:0]       word,
    output logic              wr_en,
    output logic              commit_en,
    output logic [SEL_W-1:0]  stage_sel,
    output logic [2:0]        slot_sel,
    output logic [COEF_W-1:0] wr_val
);

    dec_state_e state_q;
    addr_word_t addr_q;
    logic       live;
    logic       pad_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (strobe) begin
                    addr_q  <= addr_word_t'(word);
                    state_q <= ST_DATA;
                end
                ST_DATA: state_q <= strobe ? ST_HOLD : ST_IDLE;
                default: if (!strobe) state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pad_clear = (word[30:COEF_W] == '0);
        live      = (state_q == ST_DATA) && strobe && word[31]
                    && (addr_q.stage < 29'(STAGES));
        wr_en     = live && pad_clear && is_coef_slot(addr_q.slot);
        commit_en = live && (addr_q.slot == CMD_COMMIT);
        stage_sel = addr_q.stage[SEL_W-1:0];
        slot_sel  = addr_q.slot;
        wr_val    = word[COEF_W-1:0];
    end

endmodule

// File: rtl/coef_bank.sv
module coef_bank
    import coef_if_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int COEF_W = 25,
    parameter int SEL_W  = 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic                               commit_en,
    input  logic [SEL_W-1:0]                   stage_sel,
    input  logic [2:0]                         slot_sel,
    input  logic [COEF_W-1:0]                  wr_val,
    output logic [STAGES*NUM_SLOTS*COEF_W-1:0] active_flat,
    output logic [STAGES-1:0]                  toggle
);

    localparam int SET_W = NUM_SLOTS * COEF_W;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [SET_W-1:0] shadow_q;
        logic [SET_W-1:0] active_q;
        logic             toggle_q;
        logic             hit;

        assign hit = (stage_sel == SEL_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
                active_q <= '0;
                toggle_q <= 1'b0;
            end else begin
                for (int k = 0; k < NUM_SLOTS; k++) begin
                    if (wr_en && hit && slot_sel == 3'(k))
                        shadow_q[k*COEF_W +: COEF_W] <= wr_val;
                end
                if (commit_en && hit) begin
                    active_q <= shadow_q;
                    toggle_q <= ~toggle_q;
                end
            end
        end

        assign active_flat[s*SET_W +: SET_W] = active_q;
        assign toggle[s]                     = toggle_q;
    end

endmodule

// File: rtl/coef_cdc.sv
module coef_cdc
    import coef_if_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int COEF_W = 25
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [STAGES*NUM_SLOTS*COEF_W-1:0] active_flat,
    input  logic [STAGES-1:0]                  toggle,
    output logic [STAGES*NUM_SLOTS*COEF_W-1:0] coef_out,
    output logic [STAGES-1:0]                  upd
);

    localparam int SET_W = NUM_SLOTS * COEF_W;

    for (genvar s = 0; s < STAGES; s++) begin : g_sync
        logic [2:0]       sync_q;
        logic [SET_W-1:0] held_q;

        assign upd[s] = sync_q[1] ^ sync_q[2];

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                held_q <= '0;
            end else begin
                sync_q <= {sync_q[1:0], toggle[s]};
                if (upd[s])
                    held_q <= active_flat[s*SET_W +: SET_W];
            end
        end

        assign coef_out[s*SET_W +: SET_W] = held_q;
    end

endmodule

// File: rtl/coef_loader.sv
module coef_loader
    import coef_if_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int COEF_W = 25
) (
    input  logic                               sys_clk,
    input  logic                               sys_rst,
    input  logic                               cmd_strobe,
    input  logic [31:0]                        cmd_word,
    input  logic                               data_clk,
    input  logic                               data_rst,
    output logic [STAGES*NUM_SLOTS*COEF_W-1:0] coef_out
);

    localparam int SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    logic                               wr_en;
    logic                               commit_en;
    logic [SEL_W-1:0]                   stage_sel;
    logic [2:0]                         slot_sel;
    logic [COEF_W-1:0]                  wr_val;
    logic [STAGES*NUM_SLOTS*COEF_W-1:0] active_flat;
    logic [STAGES-1:0]                  toggle;
    logic [STAGES-1:0]                  upd;

    coef_decoder #(.STAGES(STAGES), .COEF_W(COEF_W), .SEL_W(SEL_W)) u_dec (
        .clk(sys_clk), .rst(sys_rst), .strobe(cmd_strobe), .word(cmd_word),
        .wr_en(wr_en), .commit_en(commit_en), .stage_sel(stage_sel),
        .slot_sel(slot_sel), .wr_val(wr_val)
    );

    coef_bank #(.STAGES(STAGES), .COEF_W(COEF_W), .SEL_W(SEL_W)) u_bank (
        .clk(sys_clk), .rst(sys_rst), .wr_en(wr_en), .commit_en(commit_en),
        .stage_sel(stage_sel), .slot_sel(slot_sel), .wr_val(wr_val),
        .active_flat(active_flat), .toggle(toggle)
    );

    coef_cdc #(.STAGES(STAGES), .COEF_W(COEF_W)) u_cdc (
        .clk(data_clk), .rst(data_rst), .active_flat(active_flat),
        .toggle(toggle), .coef_out(coef_out), .upd(upd)
    );

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int STAGES = 2,
    parameter int COEF_W = 25
) (
    input logic                        sys_clk,
    input logic                        sys_rst,
    input logic                        cmd_strobe,
    input logic                        wr_en,
    input logic                        commit_en,
    input logic [STAGES-1:0]           toggle,
    input logic                        data_clk,
    input logic                        data_rst,
    input logic [STAGES-1:0]           upd,
    input logic [STAGES*5*COEF_W-1:0]  coef_out
);

    AST_ACTION_AFTER_ADDR: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wr_en || commit_en) |-> $past(cmd_strobe)); // R10

    AST_ONE_ACTION_PER_STROBE: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wr_en || commit_en) |=> !(wr_en || commit_en)); // R10

    AST_COMMIT_FLIPS: assert property (@(posedge sys_clk) disable iff (sys_rst)
        commit_en |=> (toggle != $past(toggle))); // R5

    AST_TOGGLE_HELD: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !commit_en |=> $stable(toggle)); // R4

    AST_OUT_HELD: assert property (@(posedge data_clk) disable iff (data_rst)
        (upd == '0) |=> $stable(coef_out)); // R5

endmodule

bind coef_loader coef_loader_chk #(.STAGES(STAGES), .COEF_W(COEF_W)) u_chk (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .cmd_strobe(cmd_strobe),
    .wr_en(wr_en), .commit_en(commit_en), .toggle(toggle),
    .data_clk(data_clk), .data_rst(data_rst), .upd(upd), .coef_out(coef_out)
);

// File: tb/coef_loader_test.sv
`timescale 1ns/1ps
module coef_loader_test;

    localparam int STAGES = 2;
    localparam int CW     = 25;
    localparam int NV     = 13;

    logic sys_clk = 0, data_clk = 0;
    logic sys_rst = 1, data_rst = 1;
    logic cmd_strobe = 0;
    logic [31:0] cmd_word = '0;
    logic [STAGES*5*CW-1:0] coef_out;

    logic [CW-1:0] sh_m [STAGES][5];
    logic [CW-1:0] ac_m [STAGES][5];
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 sys_clk = ~sys_clk;
    always #4   data_clk = ~data_clk;

    coef_loader #(.STAGES(STAGES), .COEF_W(CW)) uut (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .cmd_strobe(cmd_strobe),
        .cmd_word(cmd_word), .data_clk(data_clk), .data_rst(data_rst),
        .coef_out(coef_out)
    );

    // {stage[3:0], slot[2:0], data word[31:0]}
    localparam logic [38:0] VEC [NV] = '{
        {4'd0, 3'd0, 32'h8000_0011},
        {4'd0, 3'd1, 32'h8000_0022},
        {4'd0, 3'd2, 32'h8000_0033},
        {4'd0, 3'd3, 32'h8100_0044},
        {4'd0, 3'd4, 32'h8000_0055},
        {4'd0, 3'd7, 32'h8000_0000},
        {4'd1, 3'd0, 32'h8000_0101},
        {4'd1, 3'd4, 32'h81FF_FFFF},
        {4'd1, 3'd7, 32'h8000_ABCD},
        {4'd0, 3'd5, 32'h8000_0999},
        {4'd1, 3'd2, 32'h0000_0777},
        {4'd3, 3'd0, 32'h8000_0888},
        {4'd0, 3'd0, 32'h8200_0001}
    };

    task automatic model_reset();
        for (int s = 0; s < STAGES; s++)
            for (int k = 0; k < 5; k++) begin
                sh_m[s][k] = '0;
                ac_m[s][k] = '0;
            end
    endtask

    task automatic send(input logic [28:0] stg, input logic [2:0] slt,
                        input logic [31:0] dw, input int extra);
        @(posedge sys_clk); #1;
        cmd_strobe = 1;
        cmd_word   = {stg, slt};
        @(posedge sys_clk); #1;
        cmd_word   = dw;
        for (int e = 0; e < extra; e++) begin
            @(posedge sys_clk); #1;
            cmd_word = 32'h8000_0FFF;
        end
        @(posedge sys_clk); #1;
        cmd_strobe = 0;
        cmd_word   = '0;
        if (dw[31] && stg < 29'(STAGES)) begin
            if (slt < 3'd5 && dw[30:CW] == '0) sh_m[stg][slt] = dw[CW-1:0];
            if (slt == 3'd7)
                for (int k = 0; k < 5; k++) ac_m[stg][k] = sh_m[stg][k];
        end
    endtask

    task automatic check_all(input string tag);
        repeat (8) @(posedge data_clk);
        @(negedge data_clk);
        for (int s = 0; s < STAGES; s++)
            for (int k = 0; k < 5; k++) begin
                logic [CW-1:0] got;
                got = coef_out[(s*5+k)*CW +: CW];
                checks++;
                if (got !== ac_m[s][k]) begin
                    failures++;
                    $display("FAIL %s stage %0d slot %0d got %h expected %h",
                             tag, s, k, got, ac_m[s][k]);
                end
            end
    endtask

    task automatic do_reset();
        @(posedge sys_clk); #1;
        sys_rst = 1; data_rst = 1;
        repeat (4) @(posedge data_clk);
        #1;
        sys_rst = 0; data_rst = 0;
        model_reset();
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge data_clk);
        #1;
        sys_rst = 0; data_rst = 0;
        check_all("R1 reset zero");

        // R2 R3 R6 R7 R9: table walk, each entry checked after it settles
        for (int i = 0; i < NV; i++) begin
            send({25'd0, VEC[i][38:35]}, VEC[i][34:32], VEC[i][31:0], 0);
            check_all("R2/R3 table");
        end

        // R7 R6: recommit both stages, ignored words must not have reached shadow
        send(29'd0, 3'd6, 32'h8000_0666, 0);
        send(29'd0, 3'd7, 32'h8000_0000, 0);
        send(29'd1, 3'd7, 32'h8000_0000, 0);
        check_all("R7 R6 ignored words");

        // R4: pending write without commit
        send(29'd0, 3'd1, 32'h8000_7777, 0);
        check_all("R4 no commit");

        // R8: commit of stage 1 leaves stage 0 pending unapplied
        send(29'd1, 3'd3, 32'h8000_0321, 0);
        send(29'd1, 3'd7, 32'h8000_0000, 0);
        check_all("R8 other stage");

        // R10: extra words while strobe held high are ignored
        send(29'd1, 3'd2, 32'h8000_0ABC, 3);
        send(29'd1, 3'd7, 32'h8000_0000, 2);
        check_all("R10 held strobe");

        // R5 R9: full stage reload with commit data bits set
        for (int k = 0; k < 5; k++)
            send(29'd0, 3'(k), 32'h8000_1000 + 32'(k), 0);
        send(29'd0, 3'd7, 32'hFFFF_FFFF, 0);
        check_all("R5 R9 full set");

        do_reset();
        check_all("R1 reset again");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements got running expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule